// File: doc/BRIEF.md
# DECT Channel Synthesizer Divider

This block sets up and runs the feedback divider of a DECT frequency synthesizer. A channel number, a transmit/receive select and an IF-option select are turned into a swallow count A and a main count M. These two counts drive a pulse-swallow divider. The divider is clocked by the output of an external 32/33 dual-modulus prescaler. For each period it produces a modulus-control level for that prescaler and one divided pulse for the phase detector. The total division is 32·M + A, so a change of one in A moves the synthesized frequency by one 1.728 MHz channel step.

A one-cycle load strobe captures new settings. They stay pending until the current division period ends, so the loop never sees a shortened or lengthened period. A direct-A override lets the controller pick any A from 0 to 31, which reaches the extended bands. A channel number outside 0..9 without the override is rejected and flagged.

Top module: `synth_chan_divider`

## Requirements
- R1: In transmit (txSel=1) a load gives M=34 and A=10−channel (channel 9 → A=1, channel 0 → A=10), whatever ifAlt is.
- R2: In receive (txSel=0) with ifAlt=0, a load gives M=32 and A=10−channel.
- R3: In receive with ifAlt=1, a load gives M=32 and A=9−channel (channel 9 → A=0, channel 0 → A=9).
- R4: With overrideEn=1, a load takes A directly from overrideA (any value 0..31), with M chosen by txSel as in R1/R2. The load is accepted for any channel number and clears chanInvalid.
- R5: A load with overrideEn=0 and channel number above 9 sets chanInvalid from the next cycle and leaves A and M unchanged. The next accepted load clears chanInvalid.
- R6: Captured settings appear on aValue/mValue, and take effect, only in the cycle after a divPulse cycle. The period in which a load is captured keeps the old settings. A load captured on the divPulse cycle itself takes effect one period later.
- R7: divPulse is high for exactly one cycle per period, in its last cycle, and a period lasts M input clock cycles.
- R8: modCtrl is high (divide-by-33) for the first A cycles of each period and low for the remaining M−A cycles.
- R9: Summed over one period, the prescaler division (33 when modCtrl is high, 32 otherwise) equals 32·M + A.
- R10: After reset, aValue=10, mValue=34, chanInvalid=0, and a new period starts with the counter at its first cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaler output clock |
| rstN | input | 1 | Active-low synchronous reset |
| chanNum | input | 4 | DECT channel number |
| txSel | input | 1 | 1 = transmit, 0 = receive |
| ifAlt | input | 1 | Receive IF option: 0 default, 1 alternate |
| overrideEn | input | 1 | Take A from overrideA |
| overrideA | input | 5 | Direct swallow count |
| loadStrobe | input | 1 | Capture new settings |
| aValue | output | 5 | Active swallow count A |
| mValue | output | 6 | Active main count M |
| modCtrl | output | 1 | 1 = prescaler divides by 33 |
| divPulse | output | 1 | One-cycle divided output |
| chanInvalid | output | 1 | Last load had an illegal channel |

## Verification
The hardest case to reach from the ports is a load whose capture edge is also the wrap edge. There the pending and active registers update on the same edge, and the new settings must wait a full extra period. The bench aligns to a divPulse cycle and raises loadStrobe on that same cycle. It also raises the strobe a few cycles into a period, and then checks that both the current period and the following one have the lengths and modCtrl counts that R6 predicts.

// File: rtl/synth_div_pkg.sv
package synth_div_pkg;

  // Strobes from the control module to the datapath.
  typedef struct packed {
    logic capture;      // latch the computed A/M into the pending registers
    logic markInvalid;  // rejected load
    logic clearInvalid; // accepted load
  } ctrlStrobe_t;

endpackage

// File: rtl/synth_div_ctrl.sv
module synth_div_ctrl
  import synth_div_pkg::*;
#(
  parameter int CHAN_W   = 4,
  parameter int A_W      = 5,
  parameter int M_W      = 6,
  parameter int NUM_CHAN = 10,
  parameter int TX_M     = 34,
  parameter int RX_M     = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CHAN_W-1:0] chanNum,
  input  logic             txSel,
  input  logic             ifAlt,
  input  logic             overrideEn,
  input  logic [A_W-1:0]   overrideA,
  input  logic             loadStrobe,
  output ctrlStrobe_t      strobe,
  output logic [A_W-1:0]   newA,
  output logic [M_W-1:0]   newM,
  output logic             chanInvalid
);

  localparam logic [CHAN_W-1:0] CHAN_LIM   = CHAN_W'(NUM_CHAN);
  localparam logic [A_W-1:0]    A_TOP_STD  = A_W'(NUM_CHAN);
  localparam logic [A_W-1:0]    A_TOP_ALT  = A_W'(NUM_CHAN - 1);
  localparam logic [M_W-1:0]    M_TX       = M_W'(TX_M);
  localparam logic [M_W-1:0]    M_RX       = M_W'(RX_M);

  logic           chanOk;
  logic           useAltIf;
  logic [A_W-1:0] mappedA;
  logic           invalidQ;

  assign chanOk   = chanNum < CHAN_LIM;
  // The alternate IF option only shifts the receive mapping.
  assign useAltIf = !txSel && ifAlt;

  always_comb begin
    mappedA = (useAltIf ? A_TOP_ALT : A_TOP_STD) - A_W'(chanNum);
    newA    = overrideEn ? overrideA : mappedA;
    newM    = txSel ? M_TX : M_RX;
  end

  always_comb begin
    strobe.capture      = loadStrobe && (overrideEn || chanOk);
    strobe.markInvalid  = loadStrobe && !overrideEn && !chanOk;
    strobe.clearInvalid = strobe.capture;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                    invalidQ <= 1'b0;
    else if (strobe.markInvalid)  invalidQ <= 1'b1;
    else if (strobe.clearInvalid) invalidQ <= 1'b0;
  end

  assign chanInvalid = invalidQ;

endmodule

// File: rtl/synth_div_datapath.sv
module synth_div_datapath
  import synth_div_pkg::*;
#(
  parameter int A_W   = 5,
  parameter int M_W   = 6,
  parameter int RST_A = 10,
  parameter int RST_M = 34
) (
  input  logic           clk,
  input  logic           rstN,
  input  ctrlStrobe_t    strobe,
  input  logic [A_W-1:0] newA,
  input  logic [M_W-1:0] newM,
  output logic [A_W-1:0] aValue,
  output logic [M_W-1:0] mValue,
  output logic           modCtrl,
  output logic           divPulse
);

  localparam logic [A_W-1:0] A_INIT = A_W'(RST_A);
  localparam logic [M_W-1:0] M_INIT = M_W'(RST_M);
  localparam logic [M_W-1:0] ONE    = M_W'(1);

  logic [A_W-1:0] pendA, actA;
  logic [M_W-1:0] pendM, actM;
  logic [M_W-1:0] mCount;
  logic           wrap;

  assign wrap = (mCount == actM - ONE);

  // Pending settings, written by an accepted load.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendA <= A_INIT;
      pendM <= M_INIT;
    end else if (strobe.capture) begin
      pendA <= newA;
      pendM <= newM;
    end
  end

  // Active settings, refreshed only at a period boundary.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      actA <= A_INIT;
      actM <= M_INIT;
    end else if (wrap) begin
      actA <= pendA;
      actM <= pendM;
    end
  end

  // Main counter: one step per prescaler output cycle.
  always_ff @(posedge clk) begin
    if (!rstN)     mCount <= '0;
    else if (wrap) mCount <= '0;
    else           mCount <= mCount + ONE;
  end

  assign modCtrl  = mCount < M_W'(actA);
  assign divPulse = wrap;
  assign aValue   = actA;
  assign mValue   = actM;

endmodule

// File: rtl/synth_chan_divider.sv
module synth_chan_divider
  import synth_div_pkg::*;
#(
  parameter int CHAN_W   = 4,
  parameter int A_W      = 5,
  parameter int M_W      = 6,
  parameter int NUM_CHAN = 10,
  parameter int TX_M     = 34,
  parameter int RX_M     = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CHAN_W-1:0] chanNum,
  input  logic              txSel,
  input  logic              ifAlt,
  input  logic              overrideEn,
  input  logic [A_W-1:0]    overrideA,
  input  logic              loadStrobe,
  output logic [A_W-1:0]    aValue,
  output logic [M_W-1:0]    mValue,
  output logic              modCtrl,
  output logic              divPulse,
  output logic              chanInvalid
);

  ctrlStrobe_t    strobe;
  logic [A_W-1:0] newA;
  logic [M_W-1:0] newM;

  synth_div_ctrl #(
    .CHAN_W(CHAN_W), .A_W(A_W), .M_W(M_W),
    .NUM_CHAN(NUM_CHAN), .TX_M(TX_M), .RX_M(RX_M)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .chanNum(chanNum), .txSel(txSel),
    .ifAlt(ifAlt), .overrideEn(overrideEn), .overrideA(overrideA),
    .loadStrobe(loadStrobe), .strobe(strobe), .newA(newA),
    .newM(newM), .chanInvalid(chanInvalid)
  );

  // Reset settings match transmit on the lowest channel number.
  synth_div_datapath #(
    .A_W(A_W), .M_W(M_W), .RST_A(NUM_CHAN), .RST_M(TX_M)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .newA(newA), .newM(newM),
    .aValue(aValue), .mValue(mValue), .modCtrl(modCtrl), .divPulse(divPulse)
  );

endmodule

// File: rtl/synth_chan_divider_chk.sv
module synth_chan_divider_chk #(
  parameter int CHAN_W   = 4,
  parameter int A_W      = 5,
  parameter int M_W      = 6,
  parameter int NUM_CHAN = 10,
  parameter int TX_M     = 34,
  parameter int RX_M     = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [CHAN_W-1:0] chanNum,
  input logic              txSel,
  input logic              ifAlt,
  input logic              overrideEn,
  input logic [A_W-1:0]    overrideA,
  input logic              loadStrobe,
  input logic [A_W-1:0]    aValue,
  input logic [M_W-1:0]    mValue,
  input logic              modCtrl,
  input logic              divPulse,
  input logic              chanInvalid
);

  // R1 / R2: M only ever takes one of the two direction values
  a_r1_m_choice: assert property (@(posedge clk) disable iff (!rstN)
    (mValue == M_W'(TX_M)) || (mValue == M_W'(RX_M)));

  // R5: rejected load raises the flag
  a_r5_invalid_flag: assert property (@(posedge clk) disable iff (!rstN)
    (loadStrobe && !overrideEn && (chanNum >= CHAN_W'(NUM_CHAN))) |=> chanInvalid);

  // R5: flag rises only after a load
  a_r5_rise_after_load: assert property (@(posedge clk) disable iff (!rstN)
    $rose(chanInvalid) |-> $past(loadStrobe));

  // R6: settings move only across a period boundary
  a_r6_hold_mid_period: assert property (@(posedge clk) disable iff (!rstN)
    !divPulse |=> ($stable(aValue) && $stable(mValue)));

  // R7: divided pulse lasts one cycle
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    divPulse |=> !divPulse);

  // R8: last cycle of a period divides by 32
  a_r8_mod_low_at_end: assert property (@(posedge clk) disable iff (!rstN)
    divPulse |-> !modCtrl);

  // R8: first cycle of a period divides by 33 unless A is zero
  a_r8_mod_at_start: assert property (@(posedge clk) disable iff (!rstN)
    divPulse |=> (modCtrl == (aValue != '0)));

endmodule

bind synth_chan_divider synth_chan_divider_chk #(
  .CHAN_W(CHAN_W), .A_W(A_W), .M_W(M_W),
  .NUM_CHAN(NUM_CHAN), .TX_M(TX_M), .RX_M(RX_M)
) u_chk (.*);

// File: tb/synth_chan_divider_tb.sv
module synth_chan_divider_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] chanNum = '0;
  logic       txSel = 1'b1;
  logic       ifAlt = 1'b0;
  logic       overrideEn = 1'b0;
  logic [4:0] overrideA = '0;
  logic       loadStrobe = 1'b0;
  logic [4:0] aValue;
  logic [5:0] mValue;
  logic       modCtrl;
  logic       divPulse;
  logic       chanInvalid;

  int checks = 0;
  int errors = 0;
  int curA = 10;
  int curM = 34;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  synth_chan_divider u_dut (
    .clk(clk), .rstN(rstN), .chanNum(chanNum), .txSel(txSel), .ifAlt(ifAlt),
    .overrideEn(overrideEn), .overrideA(overrideA), .loadStrobe(loadStrobe),
    .aValue(aValue), .mValue(mValue), .modCtrl(modCtrl), .divPulse(divPulse),
    .chanInvalid(chanInvalid)
  );

  task automatic check(input int actual, input int expected, input string tag);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
    end
  endtask

  task automatic waitPulse();
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (divPulse) return;
    end
    check(0, 1, "R7 no divPulse seen");
  endtask

  // Precondition: at the negedge of a divPulse cycle. Ends at the next one.
  task automatic measurePeriod(input int loadAt, output int len,
                               output int hi, output int ratio, output int pulses);
    len = 0; hi = 0; ratio = 0; pulses = 0;
    loadStrobe = (loadAt == 0);
    forever begin
      @(negedge clk);
      len++;
      if (modCtrl) hi++;
      ratio += modCtrl ? 33 : 32;
      loadStrobe = (len == loadAt);
      if (divPulse) begin
        pulses++;
        break;
      end
      if (len > 200) break;
    end
    loadStrobe = 1'b0;
  endtask

  task automatic checkPeriod(input int expA, input int expM, input string tag);
    int len, hi, ratio, pulses;
    measurePeriod(-1, len, hi, ratio, pulses);
    check(len, expM, {tag, " R7 period length"});
    check(pulses, 1, {tag, " R7 pulses per period"});
    check(hi, expA, {tag, " R8 modCtrl high cycles"});
    check(ratio, 32 * expM + expA, {tag, " R9 total ratio"});
    check(aValue, expA, {tag, " aValue"});
    check(mValue, expM, {tag, " mValue"});
  endtask

  // Mid-period load, then check old period is intact and next uses new values.
  task automatic configure(input int ch, input bit tx, input bit alt, input bit ovr,
                           input int ovA, input int expA, input int expM,
                           input string tag);
    int len, hi, ratio, pulses;
    chanNum = 4'(ch); txSel = tx; ifAlt = alt; overrideEn = ovr; overrideA = 5'(ovA);
    measurePeriod(3, len, hi, ratio, pulses);
    check(len, curM, {tag, " R6 load period keeps old M"});
    check(hi, curA, {tag, " R6 load period keeps old A"});
    check(aValue, curA, {tag, " R6 aValue old at pulse"});
    checkPeriod(expA, expM, tag);
    curA = expA; curM = expM;
  endtask

  task automatic testReset();
    @(negedge clk);
    check(aValue, 10, "R10 reset aValue");
    check(mValue, 34, "R10 reset mValue");
    check(chanInvalid, 0, "R10 reset chanInvalid");
    check(divPulse, 0, "R10 reset divPulse");
    check(modCtrl, 1, "R10 reset modCtrl at first cycle");
    waitPulse();
  endtask

  task automatic testTransmit();
    configure(9, 1, 1, 0, 0, 1, 34, "R1 tx ch9 ifAlt ignored");
    configure(0, 1, 0, 0, 0, 10, 34, "R1 tx ch0");
    configure(1, 1, 0, 0, 0, 9, 34, "R1 tx ch1 one step");
  endtask

  task automatic testRxDefault();
    configure(3, 0, 0, 0, 0, 7, 32, "R2 rx ch3");
    configure(0, 0, 0, 0, 0, 10, 32, "R2 rx ch0");
  endtask

  task automatic testRxAlt();
    configure(9, 0, 1, 0, 0, 0, 32, "R3 rx alt ch9");
    configure(0, 0, 1, 0, 0, 9, 32, "R3 rx alt ch0");
  endtask

  task automatic testInvalid();
    int len, hi, ratio, pulses;
    chanNum = 4'd12; txSel = 1'b1; overrideEn = 1'b0;
    measurePeriod(2, len, hi, ratio, pulses);
    check(chanInvalid, 1, "R5 flag after ch12");
    checkPeriod(curA, curM, "R5 settings unchanged");
    check(chanInvalid, 1, "R5 flag held");
    configure(4, 1, 0, 0, 0, 6, 34, "R5 recover ch4");
    check(chanInvalid, 0, "R5 flag cleared by valid load");
  endtask

  task automatic testOverride();
    int len, hi, ratio, pulses;
    chanNum = 4'd15; txSel = 1'b0; overrideEn = 1'b0;
    measurePeriod(2, len, hi, ratio, pulses);
    check(chanInvalid, 1, "R4 flag set before override");
    configure(15, 1, 0, 1, 31, 31, 34, "R4 override A31 tx");
    check(chanInvalid, 0, "R4 override clears flag");
    configure(15, 0, 1, 1, 0, 0, 32, "R4 override A0 rx");
  endtask

  task automatic testCoincident();
    int len, hi, ratio, pulses;
    chanNum = 4'd5; txSel = 1'b1; ifAlt = 1'b0; overrideEn = 1'b0;
    measurePeriod(0, len, hi, ratio, pulses);
    check(len, curM, "R6 coincident load period keeps old M");
    check(hi, curA, "R6 coincident load period keeps old A");
    checkPeriod(5, 34, "R6 coincident applied next period");
    curA = 5; curM = 34;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testTransmit();
    testRxDefault();
    testRxAlt();
    testInvalid();
    testOverride();
    testCoincident();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule